// File: doc/BRIEF.md
# In-System Programming Port Slave (Identifier Read Path)

This block is the device end of a four-wire in-system programming port. While an active-low enable input is held low, the block follows a small mode machine. The host steers it by presenting a level pair on the MODE and SDI inputs and pulsing the port clock. The same pulse also moves serial data. A pair with MODE high and SDI low returns the block to idle from any state. A pair with MODE low is the execute command.

When execute arrives in idle, the block parallel-loads an eight-bit identification register and enters the identifier-shift state. The register contents appear on SDO least significant bit first. Each falling edge of the port clock presents the next bit, so the host samples SDO on its rising edges. Further MODE-low clocks in that state push SDI into the top of the register. A MODE-high, SDI-high pair moves to a placeholder state, which stands in for the programming states. It is left only by the return-to-idle pair.

The port is a bit-level control interface and carries no stream handshake. The host alone paces every transfer with its clock, and the block can apply no back-pressure.

Top module: `isp_slave_port`

## Requirements
- R1: While en_n is high, the mode machine is held in idle, the identification register is cleared, and sdo is driven low; clocks on the port have no effect on sdo.
- R2: MODE and SDI are sampled only on rising edges of sck; sdo changes only on falling edges of sck while en_n is low.
- R3: A rising edge with mode=1 and sdi=0 puts the block in idle from any state.
- R4: In idle, a rising edge with mode=0 (sdi ignored) loads the identification register and enters the identifier-shift state; bit 0 of the identifier is on sdo after the falling edge that ends that clock.
- R5: The identifier is 8'h15 by default, so the host reads 1,0,1,0,1,0,0,0 at the rising edges of the eight mode=0 clocks that follow the load.
- R6: In the identifier-shift state, each rising edge with mode=0 shifts the register one place toward bit 0 and puts sdi in bit 7; after eight such clocks sdo replays the shifted-in bits in the order they were sent.
- R7: A rising edge with mode=1 and sdi=1 in idle or in identifier shift enters a hold state; in hold, every pair other than mode=1/sdi=0 leaves the state and the register unchanged, so an execute in hold loads nothing.
- R8: Raising en_n in the middle of an identifier shift abandons it; after en_n returns low, the first mode=0 clock is an execute that reloads the identifier from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_n | input | 1 | Active-low port enable; high acts as asynchronous reset |
| sck | input | 1 | Port clock from the host |
| mode | input | 1 | Mode-select level, sampled on rising sck |
| sdi | input | 1 | Serial data or code level, sampled on rising sck |
| sdo | output | 1 | Serial data to host, updated on falling sck |

## Verification
The bench reads the full identifier after an execute. It then keeps clocking and checks that a known pattern pushed into the register comes back in order. A design with the wrong bit order or the wrong fill end fails there. It also fails if it advances on the rising edge, because every bit would then arrive one place early. The return-to-idle pair is checked from the shift state by issuing a second execute. A design that ignored that pair would shift a zero instead of reloading the identifier. In the hold state, execute clocks must leave sdo at a known zero; a design that reloaded there would show a one. Dropping the enable mid-shift must force sdo low and restart the next read from bit 0.

// File: rtl/isp_slave_pkg.sv
package isp_slave_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ID_SHIFT = 2'd1,
    ST_HOLD     = 2'd2
  } isp_state_e;

  typedef enum logic [1:0] {
    CODE_DATA    = 2'd0,  // mode low: execute or shift
    CODE_TO_IDLE = 2'd1,  // mode high, sdi low
    CODE_ADVANCE = 2'd2   // mode high, sdi high
  } isp_code_e;
endpackage

// File: rtl/isp_code_decode.sv
module isp_code_decode
  import isp_slave_pkg::*;
(
  input  logic      mode,
  input  logic      sdi,
  output isp_code_e code
);
  always_comb begin
    if (!mode)    code = CODE_DATA;
    else if (sdi) code = CODE_ADVANCE;
    else          code = CODE_TO_IDLE;
  end
endmodule

// File: rtl/isp_mode_fsm.sv
module isp_mode_fsm
  import isp_slave_pkg::*;
(
  input  logic       en_n,
  input  logic       sck,
  input  isp_code_e  code,
  output logic       load_id,
  output logic       shift_id,
  output isp_state_e state
);
  isp_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    if (code == CODE_TO_IDLE) begin
      state_nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:     state_nxt = (code == CODE_DATA) ? ST_ID_SHIFT : ST_HOLD;
        ST_ID_SHIFT: state_nxt = (code == CODE_DATA) ? ST_ID_SHIFT : ST_HOLD;
        ST_HOLD:     state_nxt = ST_HOLD;
        default:     state_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge sck or posedge en_n) begin
    if (en_n) state <= ST_IDLE;
    else      state <= state_nxt;
  end

  assign load_id  = (state == ST_IDLE)     && (code == CODE_DATA);
  assign shift_id = (state == ST_ID_SHIFT) && (code == CODE_DATA);

  assert_force_idle_R3: assert property (@(posedge sck) disable iff (en_n)
    (code == CODE_TO_IDLE) |=> (state == ST_IDLE));

  assert_hold_keep_R7: assert property (@(posedge sck) disable iff (en_n)
    (state == ST_HOLD && code != CODE_TO_IDLE) |=> (state == ST_HOLD));

  assert_exec_enter_R4: assert property (@(posedge sck) disable iff (en_n)
    (state == ST_IDLE && code == CODE_DATA) |=> (state == ST_ID_SHIFT));
endmodule

// File: rtl/isp_id_shifter.sv
module isp_id_shifter #(
  parameter int              ID_W   = 8,
  parameter logic [ID_W-1:0] ID_VAL = 8'h15
) (
  input  logic en_n,
  input  logic sck,
  input  logic load_id,
  input  logic shift_id,
  input  logic sdi,
  output logic sdo_q
);
  logic [ID_W-1:0] sr;

  // Rising edge: capture (parallel load or serial fill at the top end)
  always_ff @(posedge sck or posedge en_n) begin
    if (en_n)          sr <= '0;
    else if (load_id)  sr <= ID_VAL;
    else if (shift_id) sr <= {sdi, sr[ID_W-1:1]};
  end

  // Falling edge: present the current low bit to the host
  always_ff @(negedge sck or posedge en_n) begin
    if (en_n) sdo_q <= 1'b0;
    else      sdo_q <= sr[0];
  end

  assert_id_load_R4: assert property (@(posedge sck) disable iff (en_n)
    load_id |=> (sr == ID_VAL));

  assert_msb_fill_R6: assert property (@(posedge sck) disable iff (en_n)
    shift_id |=> (sr[ID_W-1] == $past(sdi)));

  assert_idle_hold_R7: assert property (@(posedge sck) disable iff (en_n)
    (!load_id && !shift_id) |=> $stable(sr));
endmodule

// File: rtl/isp_slave_port.sv
module isp_slave_port
  import isp_slave_pkg::*;
#(
  parameter int              ID_W   = 8,
  parameter logic [ID_W-1:0] ID_VAL = 8'h15
) (
  input  logic en_n,
  input  logic sck,
  input  logic mode,
  input  logic sdi,
  output logic sdo
);
  isp_code_e  code;
  isp_state_e state;
  logic       load_id;
  logic       shift_id;
  logic       sdo_q;

  isp_code_decode i_decode (
    .mode (mode),
    .sdi  (sdi),
    .code (code)
  );

  isp_mode_fsm i_fsm (
    .en_n     (en_n),
    .sck      (sck),
    .code     (code),
    .load_id  (load_id),
    .shift_id (shift_id),
    .state    (state)
  );

  isp_id_shifter #(.ID_W(ID_W), .ID_VAL(ID_VAL)) i_shifter (
    .en_n     (en_n),
    .sck      (sck),
    .load_id  (load_id),
    .shift_id (shift_id),
    .sdi      (sdi),
    .sdo_q    (sdo_q)
  );

  assign sdo = en_n ? 1'b0 : sdo_q;

  assert_one_action_R2: assert property (@(posedge sck) disable iff (en_n)
    !(load_id && shift_id));
endmodule

// File: tb/test_isp_slave_port.sv
module test_isp_slave_port;
  logic en_n = 1'b1;
  logic sck  = 1'b0;
  logic mode = 1'b1;
  logic sdi  = 1'b0;
  logic sdo;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    bit    chk;
    bit    val;
    string tag;
  } exp_t;
  exp_t q[$];

  isp_slave_port i_isp_slave_port (
    .en_n(en_n), .sck(sck), .mode(mode), .sdi(sdi), .sdo(sdo)
  );

  // One 5 ns (200 MHz) port clock per call; expectation is what the host reads at the rising edge
  task automatic strobe(input bit m, input bit d, input bit chk, input bit ev, input string tag);
    exp_t e;
    e.chk = chk; e.val = ev; e.tag = tag;
    q.push_back(e);
    mode = m; sdi = d;
    #1.25 sck = 1'b1;
    #2.5  sck = 1'b0;
    #1.25;
  endtask

  task automatic direct(input bit ev, input string tag);
    n_checks++;
    if (sdo !== ev) begin
      n_fail++;
      $display("FAIL %s: sdo=%b expected %b", tag, sdo, ev);
    end
  endtask

  // Monitor: compare sdo at every rising edge against the scoreboard
  initial begin
    forever begin
      @(posedge sck);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.chk) begin
          n_checks++;
          if (sdo !== e.val) begin
            n_fail++;
            $display("FAIL %s: sdo=%b expected %b", e.tag, sdo, e.val);
          end
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] id_exp  = 8'h15;
    logic [7:0] pattern = 8'hC6;
    #7;
    direct(1'b0, "R1 reset sdo");
    strobe(1'b0, 1'b0, 1, 1'b0, "R1 disabled clock");
    strobe(1'b0, 1'b1, 1, 1'b0, "R1 disabled clock");
    direct(1'b0, "R1 disabled after clocks");

    en_n = 1'b0; #5;
    strobe(1'b0, 1'b0, 1, 1'b0, "R4 before load");
    for (int i = 0; i < 8; i++)
      strobe(1'b0, pattern[i], 1, id_exp[i], (i == 0) ? "R4 first bit" : "R5 id bit");
    for (int i = 0; i < 8; i++)
      strobe(1'b0, 1'b0, 1, pattern[i], "R6 replay");

    // R3: force idle from shift, then a fresh execute must reload
    strobe(1'b1, 1'b0, 1, 1'b0, "R3 to idle");
    strobe(1'b0, 1'b0, 1, 1'b0, "R3 exec");
    strobe(1'b0, 1'b0, 1, 1'b1, "R3 reload bit0");

    // R7: hold state ignores execute
    strobe(1'b1, 1'b1, 1, 1'b0, "R7 enter hold");
    strobe(1'b0, 1'b0, 1, 1'b0, "R7 hold exec");
    strobe(1'b0, 1'b1, 1, 1'b0, "R7 hold exec");
    strobe(1'b0, 1'b0, 1, 1'b0, "R7 hold exec");
    strobe(1'b1, 1'b1, 1, 1'b0, "R7 hold advance");
    strobe(1'b1, 1'b0, 1, 1'b0, "R7 leave hold");
    strobe(1'b0, 1'b1, 1, 1'b0, "R7 exec after hold");
    strobe(1'b0, 1'b0, 1, 1'b1, "R7 bit0 after hold");
    strobe(1'b0, 1'b0, 1, 1'b0, "R2 bit1");
    strobe(1'b0, 1'b0, 1, 1'b1, "R2 bit2");

    // R8: abandon shift by disabling
    #2;
    en_n = 1'b1; #1;
    direct(1'b0, "R8 disabled mid shift");
    #2;
    en_n = 1'b0; #5;
    strobe(1'b0, 1'b0, 1, 1'b0, "R8 exec after enable");
    for (int i = 0; i < 8; i++)
      strobe(1'b0, 1'b0, 1, id_exp[i], "R8 reread");

    #10;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule